// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame should be kept, based only on its 48-bit destination address. The address reaches the block either one bit per cycle, in the order the bits crossed the wire, or eight bits per cycle as bytes whose least significant bit is the earliest wire bit. A start-of-frame strobe opens each address window. After the 48th bit the block issues one verdict, accept or reject, together with a one-cycle done strobe.

The verdict follows a fixed priority. The promiscuous setting wins over everything else. Next comes the all-ones broadcast address, which has its own enable rule and never consults the hash table. Other group addresses, those whose first wire bit is 1, are looked up in a 64-entry hash table indexed by CRC-32 bits. Individual addresses must equal the programmed station address in every bit. Frame storage, FCS checking and any host access are handled elsewhere.

Top module: `rx_dst_filter`

## Requirements
- R1: While reset is high and after it is released, `done_o` and `accept_o` are both 0 until the first verdict.
- R2: On the serial input, the k-th address bit received after the start strobe is compared with `sta_addr_i[k]`. Conventional address byte n occupies bits [8n+7:8n], least significant bit first on the wire. A frame whose first bit is 0 is accepted, when the block is not promiscuous, only if all 48 bits equal the station address.
- R3: A byte beat delivers eight wire bits, `byt_data_i[0]` first. When a byte beat and a serial beat are presented in the same cycle, the byte is taken and the serial bit is ignored.
- R4: The all-ones address is classed as broadcast and bypasses the hash table. With `bcast_dis_i` = 0 it is accepted, even when the hash table is all zeros.
- R5: With `bcast_dis_i` = 1, broadcast is rejected when `promisc_i` = 0 and accepted when `promisc_i` = 1.
- R6: A non-broadcast address whose first wire bit is 1 is a group address. Its hash index is bits [31:26] of a CRC register, read as an unsigned number with bit 31 as the MSB. That register is preset to all ones and updated for each of the 48 wire bits in order with the reflected polynomial 0xEDB88320, with no final inversion. The frame is accepted when `hash_tbl_i[index]` is 1.
- R7: With `hash_tbl_i` all zeros and `promisc_i` = 0, every non-broadcast group address is rejected.
- R8: With `promisc_i` = 1, every frame is accepted, whatever its destination.
- R9: `done_o` is high for exactly the one cycle after the clock edge that takes the 48th bit. `accept_o` is updated at that same edge and holds its value until the next verdict.
- R10: The start strobe clears all partial state, and a data beat presented in the same cycle counts as the first bit of the new frame. Data beats presented outside an open window, either before any start strobe or after the 48th bit, produce no verdict.
- R11: The configuration inputs are sampled at the edge that takes the 48th bit. Changes made after that edge do not alter the verdict already given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start of a new destination address window |
| ser_vld_i | input | 1 | Serial address bit valid |
| ser_bit_i | input | 1 | Serial address bit, wire order |
| byt_vld_i | input | 1 | Address byte valid |
| byt_data_i | input | 8 | Address byte, bit 0 earliest on wire |
| sta_addr_i | input | 48 | Station address, bit k compared with wire bit k |
| hash_tbl_i | input | 64 | Group address hash table |
| bcast_dis_i | input | 1 | Reject broadcast unless promiscuous |
| promisc_i | input | 1 | Accept every frame |
| done_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Verdict, held until the next one |

## Verification
Individual addresses are sent once with an exact match and once with a single bit flipped in the top byte. This separates a full 48-bit comparison from a partial one, and it shows whether the byte-to-bit mapping is correct. The broadcast address is run under all four settings of the broadcast-disable and promiscuous controls, and once more with an empty hash table, to show that broadcast never reaches the hash. A group address is sent with only its computed table bit set, and again with every bit except that one set, so that a wrong CRC index reverses the result. Further frames cover mixed serial and byte beats, windows cut short by a new start strobe, stray beats before and after a window, and a configuration change made right after the final bit.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  // one reflected CRC-32 update for a single wire bit
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = c[0] ^ d;
    crc_bit = fb ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
  endfunction
endpackage

// File: rtl/dafilt_feed.sv
module dafilt_feed #(
  parameter int ADDR_W = 48,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 6,
  parameter int NB_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              ser_vld_i,
  input  logic              ser_bit_i,
  input  logic              byt_vld_i,
  input  logic [BYTE_W-1:0] byt_data_i,
  output logic [CNT_W-1:0]  pos_o,
  output logic [NB_W-1:0]   nbits_o,
  output logic [BYTE_W-1:0] dvec_o,
  output logic              fresh_o,
  output logic              last_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base, avail;
  logic             live;

  always_comb begin
    base    = sof_i ? '0 : cnt_q;
    live    = sof_i | armed_q;
    avail   = CNT_W'(ADDR_W) - base;
    fresh_o = sof_i;
    pos_o   = base;
    dvec_o  = byt_vld_i ? byt_data_i : {{(BYTE_W-1){1'b0}}, ser_bit_i};
    if (!live)
      nbits_o = '0;
    else if (byt_vld_i)
      nbits_o = (avail >= CNT_W'(BYTE_W)) ? NB_W'(BYTE_W) : NB_W'(avail);
    else if (ser_vld_i)
      nbits_o = (avail != '0) ? NB_W'(1) : '0;
    else
      nbits_o = '0;
    last_o = (nbits_o != '0) && ((base + CNT_W'(nbits_o)) == CNT_W'(ADDR_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= live & ~last_o;
      if (nbits_o != '0)
        cnt_q <= base + CNT_W'(nbits_o);
      else if (sof_i)
        cnt_q <= '0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(ADDR_W)); // R10
  AST_IDLE_NO_LAST: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !sof_i) |-> !last_o); // R10
endmodule

// File: rtl/dafilt_crc.sv
module dafilt_crc
  import dafilt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NB_W   = 4,
  parameter int HIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fresh_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic [BYTE_W-1:0] dvec_i,
  output logic [HIDX_W-1:0] idx_nxt_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = fresh_i ? CRC_SEED : crc_q;
    for (int i = 0; i < BYTE_W; i++) begin
      if (NB_W'(i) < nbits_i)
        crc_d = crc_bit(crc_d, dvec_i[i]);
    end
    idx_nxt_o = crc_d[CRC_W-1 -: HIDX_W];
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= CRC_SEED;
    else     crc_q <= crc_d;
  end
endmodule

// File: rtl/dafilt_cmp.sv
module dafilt_cmp #(
  parameter int ADDR_W = 48,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 6,
  parameter int NB_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fresh_i,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic [BYTE_W-1:0] dvec_i,
  input  logic [ADDR_W-1:0] sta_addr_i,
  output logic              hit_nxt_o,
  output logic              grp_nxt_o,
  output logic              ones_nxt_o,
  output logic              grp_q_o,
  output logic              ones_q_o
);
  logic hit_q, grp_q, ones_q;

  always_comb begin
    logic [CNT_W-1:0] idx;
    idx        = '0;
    hit_nxt_o  = fresh_i ? 1'b1 : hit_q;
    grp_nxt_o  = fresh_i ? 1'b0 : grp_q;
    ones_nxt_o = fresh_i ? 1'b1 : ones_q;
    for (int i = 0; i < BYTE_W; i++) begin
      if (NB_W'(i) < nbits_i) begin
        idx = pos_i + CNT_W'(i);
        if (dvec_i[i] != sta_addr_i[idx]) hit_nxt_o = 1'b0;
        if (!dvec_i[i]) ones_nxt_o = 1'b0;
        if (idx == '0) grp_nxt_o = dvec_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b1;
      grp_q  <= 1'b0;
      ones_q <= 1'b1;
    end else begin
      hit_q  <= hit_nxt_o;
      grp_q  <= grp_nxt_o;
      ones_q <= ones_nxt_o;
    end
  end

  assign grp_q_o  = grp_q;
  assign ones_q_o = ones_q;
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter #(
  parameter int ADDR_W = 48,
  parameter int HASH_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              ser_vld_i,
  input  logic              ser_bit_i,
  input  logic              byt_vld_i,
  input  logic [BYTE_W-1:0] byt_data_i,
  input  logic [ADDR_W-1:0] sta_addr_i,
  input  logic [HASH_W-1:0] hash_tbl_i,
  input  logic              bcast_dis_i,
  input  logic              promisc_i,
  output logic              done_o,
  output logic              accept_o
);
  localparam int CNT_W  = $clog2(ADDR_W + 1);
  localparam int NB_W   = $clog2(BYTE_W + 1);
  localparam int HIDX_W = $clog2(HASH_W);

  logic [CNT_W-1:0]  pos;
  logic [NB_W-1:0]   nbits;
  logic [BYTE_W-1:0] dvec;
  logic              fresh, last;
  logic [HIDX_W-1:0] hidx;
  logic              hit_nxt, grp_nxt, ones_nxt, grp_q, ones_q;
  logic              verdict;

  dafilt_feed #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_feed (
    .clk(clk), .rst(rst), .sof_i(sof_i), .ser_vld_i(ser_vld_i), .ser_bit_i(ser_bit_i),
    .byt_vld_i(byt_vld_i), .byt_data_i(byt_data_i), .pos_o(pos), .nbits_o(nbits),
    .dvec_o(dvec), .fresh_o(fresh), .last_o(last));

  dafilt_crc #(.BYTE_W(BYTE_W), .NB_W(NB_W), .HIDX_W(HIDX_W)) u_crc (
    .clk(clk), .rst(rst), .fresh_i(fresh), .nbits_i(nbits), .dvec_i(dvec),
    .idx_nxt_o(hidx));

  dafilt_cmp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .NB_W(NB_W)) u_cmp (
    .clk(clk), .rst(rst), .fresh_i(fresh), .pos_i(pos), .nbits_i(nbits), .dvec_i(dvec),
    .sta_addr_i(sta_addr_i), .hit_nxt_o(hit_nxt), .grp_nxt_o(grp_nxt),
    .ones_nxt_o(ones_nxt), .grp_q_o(grp_q), .ones_q_o(ones_q));

  // priority: promiscuous, broadcast, group hash, individual match
  always_comb begin
    if (promisc_i)     verdict = 1'b1;
    else if (ones_nxt) verdict = ~bcast_dis_i;
    else if (grp_nxt)  verdict = hash_tbl_i[hidx];
    else               verdict = hit_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      done_o <= last;
      if (last) accept_o <= verdict;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_ACCEPT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(accept_o)); // R9
  AST_PROMISC_TAKES: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(promisc_i)) |-> accept_o); // R8
  AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (done_o && ones_q && $past(bcast_dis_i && !promisc_i)) |-> !accept_o); // R5
  AST_ZERO_HASH: assert property (@(posedge clk) disable iff (rst)
    (done_o && grp_q && !ones_q && $past(hash_tbl_i == '0 && !promisc_i)) |-> !accept_o); // R7
endmodule

// File: tb/test_rx_dst_filter.sv
module test_rx_dst_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof = 1'b0, ser_vld = 1'b0, ser_bit = 1'b0, byt_vld = 1'b0;
  logic [7:0]  byt_data = '0;
  logic [47:0] sta = 48'h5A_34_12_CD_AB_02;
  logic [63:0] hash = '0;
  logic        bdis = 1'b0, prom = 1'b0;
  logic        done, accept;

  int    checks = 0, errors = 0;
  logic  mon_on = 1'b0, exp_done = 1'b0, exp_acc = 1'b0, last_acc = 1'b0;
  string exp_tag = "R9";
  logic  finished = 1'b0;

  always #10 clk = ~clk;

  rx_dst_filter i_rx_dst_filter (
    .clk(clk), .rst(rst), .sof_i(sof), .ser_vld_i(ser_vld), .ser_bit_i(ser_bit),
    .byt_vld_i(byt_vld), .byt_data_i(byt_data), .sta_addr_i(sta), .hash_tbl_i(hash),
    .bcast_dis_i(bdis), .promisc_i(prom), .done_o(done), .accept_o(accept));

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      if (r[0] ^ a[k]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r[31:26];
  endfunction

  function automatic logic ref_verdict(input logic [47:0] a);
    if (prom) return 1'b1;
    if (a == '1) return ~bdis;
    if (a[0]) return hash[ref_idx(a)];
    return a == sta;
  endfunction

  // reference comparison every clock, sampled after the edge settles
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      checks++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL %s done actual %0b expected %0b", exp_tag, done, exp_done);
      end
      checks++;
      if (exp_done) begin
        if (accept !== exp_acc) begin
          errors++;
          $display("FAIL %s accept actual %0b expected %0b", exp_tag, accept, exp_acc);
        end
        last_acc = exp_acc;
      end else if (accept !== last_acc) begin
        errors++;
        $display("FAIL R9 accept held actual %0b expected %0b", accept, last_acc);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    sof = 1'b0; ser_vld = 1'b0; byt_vld = 1'b0; exp_done = 1'b0;
  endtask

  // mode 0 serial, 1 bytes, 2 bytes with a conflicting serial beat
  task automatic send(input logic [47:0] a, input int mode, input string tag,
                      input int tail, input logic flip);
    logic e;
    e = ref_verdict(a);
    exp_tag = tag;
    if (mode == 0) begin
      for (int k = 0; k < 48; k++) begin
        @(negedge clk);
        sof = (k == 0); ser_vld = 1'b1; ser_bit = a[k]; byt_vld = 1'b0;
        if (k == 47) begin exp_done = 1'b1; exp_acc = e; end
      end
    end else begin
      for (int n = 0; n < 6; n++) begin
        @(negedge clk);
        sof = (n == 0); byt_vld = 1'b1; byt_data = a[8*n +: 8];
        ser_vld = (mode == 2); ser_bit = ~a[8*n];
        if (n == 5) begin exp_done = 1'b1; exp_acc = e; end
      end
    end
    @(negedge clk);
    sof = 1'b0; byt_vld = 1'b0; ser_vld = 1'b0; exp_done = 1'b0;
    if (flip) prom = ~prom;
    for (int t = 0; t < tail; t++) begin
      @(negedge clk);
      ser_vld = 1'b1; ser_bit = t[0];
    end
    idle();
  endtask

  task automatic partial(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sof = (k == 0); ser_vld = 1'b1; ser_bit = k[1];
    end
  endtask

  initial begin
    logic [47:0] mc;
    logic [5:0]  mi;
    mc = 48'h33_00_5E_01_00_01;
    mi = ref_idx(mc);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || accept !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset done/accept actual %0b%0b expected 00", done, accept);
    end
    mon_on = 1'b1;

    // R10: stray beats before any start strobe
    exp_tag = "R10";
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); ser_vld = 1'b1; ser_bit = 1'b1;
    end
    idle();

    send(sta, 0, "R2", 0, 1'b0);                         // unicast hit serial
    send(sta ^ 48'h01_00_00_00_00_00, 0, "R2", 0, 1'b0); // miss at bit 40
    send(sta, 1, "R3", 0, 1'b0);                         // hit as bytes
    send(sta, 2, "R3", 0, 1'b0);                         // byte wins
    send(sta ^ 48'h80, 1, "R3", 0, 1'b0);                // byte miss

    // R4/R5 broadcast, four control combinations, and empty hash
    hash = '0;
    bdis = 1'b0; prom = 1'b0; send('1, 0, "R4", 0, 1'b0);
    bdis = 1'b0; prom = 1'b1; send('1, 1, "R4", 0, 1'b0);
    bdis = 1'b1; prom = 1'b0; send('1, 0, "R5", 0, 1'b0);
    bdis = 1'b1; prom = 1'b1; send('1, 1, "R5", 0, 1'b0);
    bdis = 1'b0; prom = 1'b0;

    // R6 group address hash hit and miss
    hash = 64'd1 << mi;
    send(mc, 0, "R6", 0, 1'b0);
    hash = ~(64'd1 << mi);
    send(mc, 1, "R6", 0, 1'b0);
    hash = '0;
    send(mc, 0, "R7", 0, 1'b0);
    send(48'hFF_FF_FF_FF_FF_FD ^ 48'h2, 1, "R4", 0, 1'b0); // all ones again
    send(48'h00_00_00_00_00_01, 0, "R7", 0, 1'b0);

    // R8 promiscuous overrides misses
    prom = 1'b1;
    send(sta ^ 48'h4, 0, "R8", 0, 1'b0);
    send(mc, 1, "R8", 0, 1'b0);
    prom = 1'b0;

    // R11 config change right after the last bit
    send(sta ^ 48'h100, 0, "R11", 0, 1'b1);
    prom = 1'b0;

    // R10 abort mid-window, then overrun beats after a complete window
    partial(20);
    send(sta, 0, "R10", 12, 1'b0);
    partial(30);
    send(sta, 1, "R10", 0, 1'b0);

    repeat (3) idle();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule